// File: doc/BRIEF.md
# Video Frame Sync Trigger Unit

This block owns the shared frame-sync pin of a video output engine. Configuration selects one of three roles for the pin: a frame-sync input, a frame-sync output that marks every field start, or an end-of-message strobe used while the engine runs in message-passing mode. In the input role the pin first crosses a two-stage synchronizer. Only then is an edge of the configured polarity detected.

When external sync is enabled and the pin is an input, the first qualifying edge after reset sends a single-cycle start command to the video engine. A field counter then follows the engine's field-done pulses and closes the burst after exactly two fields. A sticky status flag records that the one-shot has been spent. Every later edge is ignored until the next reset.

Top module: `vfs_trigger`

## Requirements
- R1: After a synchronous reset, `burst_start`, `burst_active`, `triggered` and `pin_out` are all 0.
- R2: `pin_oe` is 1 when `cfg_pin_mode` is 2'b01 (frame-sync output) or 2'b10 (end-of-message output). It is 0 for 2'b00 (frame-sync input) and for the unused code 2'b11.
- R3: In mode 2'b01, a one-cycle `field_start` pulse produces a one-cycle high pulse on `pin_out` in the following cycle.
- R4: In mode 2'b10, a one-cycle `msg_end` pulse produces a one-cycle high pulse on `pin_out` in the following cycle. In any other mode `msg_end` has no effect on `pin_out`.
- R5: In mode 2'b00 with `cfg_ext_sync`=1 and `cfg_edge_fall`=0, a rising edge on `pin_in` raises `burst_start` for exactly one cycle. The pulse appears on the third clock edge after the pin change (two synchronizer flops, then the command register).
- R6: With `cfg_edge_fall`=1 and otherwise the same conditions, a falling edge on `pin_in` triggers the burst with the same latency.
- R7: `burst_active` rises together with `burst_start`. It stays high across the first `field_done` pulse and falls in the cycle after the second one is sampled.
- R8: After the first trigger, `triggered` stays 1 and no further `burst_start` is produced until the next reset, whatever edges arrive.
- R9: Edges on `pin_in` start no burst and leave `triggered` at 0 when `cfg_ext_sync`=0 or when the pin is not in input mode.
- R10: An edge of the polarity that is not selected starts no burst and leaves `triggered` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pin_mode | input | 2 | Pin role: 00 sync in, 01 sync out, 10 end-of-message out, 11 unused (input) |
| cfg_edge_fall | input | 1 | 1 selects the falling edge as trigger, 0 the rising edge |
| cfg_ext_sync | input | 1 | Enables the external-sync trigger |
| pin_in | input | 1 | Level received from the pin (asynchronous) |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Output enable of the pin driver |
| field_start | input | 1 | Engine pulse at the start of each field |
| field_done | input | 1 | Engine pulse at the end of each field |
| msg_end | input | 1 | Engine pulse at the end of a message |
| burst_start | output | 1 | One-cycle command to the engine to emit a burst |
| burst_active | output | 1 | High while the two-field burst is in progress |
| triggered | output | 1 | Sticky status: the one-shot trigger has been used |

## Verification
The assertions assume that the engine signals `field_start`, `field_done` and `msg_end` as single-cycle pulses. They also assume that configuration is only changed while no pulse is in flight, so an output pulse always belongs to the mode that was in force when it was captured. The stimulus drives every engine strobe for exactly one cycle. It changes the mode only after several idle cycles and holds `pin_in` steady long enough for the synchronizer to settle between edges.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [1:0] {
        PIN_SYNC_IN  = 2'b00,
        PIN_SYNC_OUT = 2'b01,
        PIN_EOM_OUT  = 2'b10,
        PIN_UNUSED   = 2'b11
    } pin_role_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    // True when the role places the block in control of the pin.
    function automatic logic role_drives(input pin_role_e role);
        return (role == PIN_SYNC_OUT) || (role == PIN_EOM_OUT);
    endfunction

    // Pick the edge event of the configured polarity.
    function automatic logic pick_edge(input edge_evt_t evt, input logic use_fall);
        return use_fall ? evt.fall : evt.rise;
    endfunction

endpackage

// File: rtl/vfs_sync_edge.sv
module vfs_sync_edge
    import vfs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_in,
    output edge_evt_t evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[TOP];
    end

    always_comb begin
        evt.rise = chain_q[TOP] & ~last_q;
        evt.fall = ~chain_q[TOP] & last_q;
    end

endmodule

// File: rtl/vfs_burst_ctrl.sv
module vfs_burst_ctrl #(
    parameter int FIELDS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_req,
    input  logic field_done,
    output logic burst_start,
    output logic burst_active,
    output logic triggered
);
    localparam int CW = (FIELDS > 1) ? $clog2(FIELDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(FIELDS - 1);

    logic [CW-1:0] fcnt_q;
    logic          fire;

    assign fire = fire_req & ~triggered;

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_start  <= 1'b0;
            burst_active <= 1'b0;
            triggered    <= 1'b0;
            fcnt_q       <= '0;
        end else begin
            burst_start <= 1'b0;
            if (fire) begin
                burst_start  <= 1'b1;
                burst_active <= 1'b1;
                triggered    <= 1'b1;
                fcnt_q       <= '0;
            end else if (burst_active && field_done) begin
                if (fcnt_q == LAST) begin
                    burst_active <= 1'b0;
                    fcnt_q       <= '0;
                end else begin
                    fcnt_q <= fcnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vfs_pin_drive.sv
module vfs_pin_drive
    import vfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_role_e role,
    input  logic      field_start,
    input  logic      msg_end,
    output logic      pin_out,
    output logic      pin_oe
);
    logic strobe_d;

    always_comb begin
        unique case (role)
            PIN_SYNC_OUT: strobe_d = field_start;
            PIN_EOM_OUT:  strobe_d = msg_end;
            default:      strobe_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pin_out <= 1'b0;
        else     pin_out <= strobe_d;
    end

    assign pin_oe = role_drives(role);

endmodule

// File: rtl/vfs_trigger.sv
module vfs_trigger
    import vfs_pkg::*;
#(
    parameter int SYNC_STAGES      = 2,
    parameter int FIELDS_PER_BURST = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_pin_mode,
    input  logic       cfg_edge_fall,
    input  logic       cfg_ext_sync,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    input  logic       field_start,
    input  logic       field_done,
    input  logic       msg_end,
    output logic       burst_start,
    output logic       burst_active,
    output logic       triggered
);
    pin_role_e role;
    edge_evt_t evt;
    logic      fire_req;

    assign role = pin_role_e'(cfg_pin_mode);

    vfs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .evt      (evt)
    );

    assign fire_req = (role == PIN_SYNC_IN) & cfg_ext_sync
                    & pick_edge(evt, cfg_edge_fall);

    vfs_burst_ctrl #(.FIELDS(FIELDS_PER_BURST)) u_burst (
        .clk          (clk),
        .rst          (rst),
        .fire_req     (fire_req),
        .field_done   (field_done),
        .burst_start  (burst_start),
        .burst_active (burst_active),
        .triggered    (triggered)
    );

    vfs_pin_drive u_drive (
        .clk         (clk),
        .rst         (rst),
        .role        (role),
        .field_start (field_start),
        .msg_end     (msg_end),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

endmodule

// File: rtl/vfs_trigger_chk.sv
module vfs_trigger_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_pin_mode,
    input logic       field_start,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       burst_start,
    input logic       burst_active,
    input logic       triggered
);
    // R2
    oe_off_in_input_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_pin_mode == 2'b00) |-> !pin_oe);

    // R3
    sync_out_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_out && cfg_pin_mode == 2'b01 && $past(cfg_pin_mode) == 2'b01)
            |-> $past(field_start));

    // R5
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !burst_start);

    // R7
    start_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> (burst_active && triggered));

    // R8
    trig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        triggered |=> triggered);

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        triggered |=> !burst_start);
endmodule

bind vfs_trigger vfs_trigger_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_pin_mode (cfg_pin_mode),
    .field_start  (field_start),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .burst_start  (burst_start),
    .burst_active (burst_active),
    .triggered    (triggered)
);

// File: tb/vfs_trigger_tb.sv
module vfs_trigger_tb;

    typedef struct {
        int    at;
        int    kind;   // 0 = burst_start pulse, 1 = pin_out pulse
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_pin_mode = 2'b00;
    logic       cfg_edge_fall = 1'b0;
    logic       cfg_ext_sync = 1'b0;
    logic       pin_in = 1'b0;
    logic       field_start = 1'b0;
    logic       field_done = 1'b0;
    logic       msg_end = 1'b0;
    logic       pin_out, pin_oe, burst_start, burst_active, triggered;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    vfs_trigger u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_pin_mode (cfg_pin_mode),
        .cfg_edge_fall(cfg_edge_fall),
        .cfg_ext_sync (cfg_ext_sync),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .field_start  (field_start),
        .field_done   (field_done),
        .msg_end      (msg_end),
        .burst_start  (burst_start),
        .burst_active (burst_active),
        .triggered    (triggered)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulse(input int delay, input int kind, input string req);
        exp_t e;
        e.at = cyc + delay; e.kind = kind; e.req = req;
        sb.push_back(e);
    endtask

    task automatic see_pulse(input int kind);
        string nm;
        nm = (kind == 0) ? "burst_start" : "pin_out";
        if (sb.size() == 0 || sb[0].kind != kind || sb[0].at != cyc) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: unexpected %s pulse, actual 1 expected 0 (cycle %0d)",
                     (sb.size() != 0) ? sb[0].req : "R4/R8/R9/R10", nm, cyc);
        end else begin
            chk(1'b1, sb[0].req, 1, 1);
            void'(sb.pop_front());
        end
    endtask

    // Monitor: compares produced pulses against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (burst_start) see_pulse(0);
            if (pin_out)     see_pulse(1);
            while (sb.size() != 0 && sb[0].at < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: missing pulse kind %0d, actual 0 expected 1 (due %0d)",
                         sb[0].req, sb[0].kind, sb[0].at);
                void'(sb.pop_front());
            end
        end
    end

    task automatic pulse_field_start(); field_start = 1'b1; tick(1); field_start = 1'b0; endtask
    task automatic pulse_msg_end();     msg_end = 1'b1;     tick(1); msg_end = 1'b0;     endtask
    task automatic pulse_field_done();  field_done = 1'b1;  tick(1); field_done = 1'b0;  endtask

    task automatic do_reset();
        rst = 1'b1; tick(3); rst = 1'b0; tick(1);
    endtask

    initial begin
        tick(1);
        do_reset();
        // R1 reset state
        chk(burst_start == 0, "R1", burst_start, 0);
        chk(burst_active == 0, "R1", burst_active, 0);
        chk(triggered == 0, "R1", triggered, 0);
        chk(pin_out == 0, "R1", pin_out, 0);

        // R2 output enable per role
        cfg_pin_mode = 2'b00; tick(1); chk(pin_oe == 0, "R2", pin_oe, 0);
        cfg_pin_mode = 2'b01; tick(1); chk(pin_oe == 1, "R2", pin_oe, 1);
        cfg_pin_mode = 2'b10; tick(1); chk(pin_oe == 1, "R2", pin_oe, 1);
        cfg_pin_mode = 2'b11; tick(1); chk(pin_oe == 0, "R2", pin_oe, 0);

        // R3 frame-sync output pulses
        cfg_pin_mode = 2'b01; tick(3);
        expect_pulse(1, 1, "R3"); pulse_field_start(); tick(1);
        chk(pin_out == 0, "R3", pin_out, 0);
        tick(3);
        expect_pulse(1, 1, "R3"); pulse_field_start(); tick(4);
        pulse_field_done(); tick(2);   // no burst: not active
        chk(burst_active == 0, "R7", burst_active, 0);

        // R4 end-of-message strobe, and ignored in other roles
        cfg_pin_mode = 2'b10; tick(3);
        expect_pulse(1, 1, "R4"); pulse_msg_end(); tick(4);
        cfg_pin_mode = 2'b01; tick(3);
        pulse_msg_end(); tick(1);
        chk(pin_out == 0, "R4", pin_out, 0);
        cfg_pin_mode = 2'b00; tick(3);
        pulse_msg_end(); tick(1);
        chk(pin_out == 0, "R4", pin_out, 0);

        // R9 edges without external sync, and in output role
        cfg_ext_sync = 1'b0; cfg_pin_mode = 2'b00;
        pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(6);
        chk(triggered == 0, "R9", triggered, 0);
        cfg_ext_sync = 1'b1; cfg_pin_mode = 2'b01;
        pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(6);
        chk(triggered == 0, "R9", triggered, 0);

        // R10 unselected polarity ignored; R6 selected falling edge fires
        cfg_pin_mode = 2'b00; cfg_edge_fall = 1'b1; tick(3);
        pin_in = 1'b1; tick(6);
        chk(triggered == 0, "R10", triggered, 0);
        pin_in = 1'b0; expect_pulse(3, 0, "R6"); tick(3);
        chk(triggered == 1, "R6", triggered, 1);
        chk(burst_active == 1, "R7", burst_active, 1);

        // R7 two fields close the burst
        tick(2);
        pulse_field_done();
        chk(burst_active == 1, "R7", burst_active, 1);
        tick(3);
        pulse_field_done();
        chk(burst_active == 0, "R7", burst_active, 0);

        // R8 later edges ignored, flag sticky
        pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(6);
        cfg_edge_fall = 1'b0;
        pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(6);
        chk(triggered == 1, "R8", triggered, 1);
        chk(burst_active == 0, "R8", burst_active, 0);

        // R5 after a fresh reset the rising edge arms again
        do_reset();
        chk(triggered == 0, "R1", triggered, 0);
        cfg_edge_fall = 1'b0; tick(2);
        pin_in = 1'b1; expect_pulse(3, 0, "R5"); tick(2);
        chk(burst_start == 0, "R5", burst_start, 0);
        tick(1);
        chk(burst_start == 1, "R5", burst_start, 1);
        tick(1);
        chk(burst_start == 0, "R5", burst_start, 0);
        chk(triggered == 1, "R5", triggered, 1);

        tick(6);
        chk(sb.size() == 0, "R5", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule